// File: doc/BRIEF.md
# Power Mode Controller with Clock Guard

This block sequences a microcontroller core between two power modes, Active and Idle, and drives the enable of the high-frequency clock generator. Software sets up an Idle request in a byte-wide control/status register. The actual move into Idle takes place only when the core signals that it has executed its wait instruction. A hardware wake-up event clears the request bits and brings the core back to Active.

Two clock-stable indications, one from each clock generator, protect every mode change. They arrive asynchronously and pass through two-flop synchronizers. If the clock that the target mode needs is not yet stable, the change is held pending and a stall output stays high. The change completes by itself as soon as that clock reports stable. The register reads back both synchronized indications.

In Active mode the high-frequency generator enable is always high. In Idle mode the enable follows the inverse of the oscillator-disable bit. This means the oscillator is switched off only once Idle has actually been reached.

Top module: `pwr_mode_ctl`

## Requirements
- R1: After reset, the writable register bits are 0, `mode_idle` is 0 (Active), `hf_gen_en` is 1, `stall` is 0, and the read value is 0x00.
- R2: The register bits that software can write are bit 1 (oscillator disable), bit 2 (idle request) and bit 5 (wait-arm). Bits 0, 3 and 4 always read 0. Writes to bits 0, 3, 4, 6 and 7 have no effect.
- R3: Read bit 6 shows the high-frequency stable input and read bit 7 shows the low-frequency stable input. Each bit reflects a change of its input at the second rising clock edge after the input changes.
- R4: The block leaves Active for Idle (`mode_idle` = 1) only on a wait strobe that arrives while bits 2 and 5 are both 1. A wait strobe with bit 5 at 0 leaves the block in Active.
- R5: `hf_gen_en` is 1 throughout Active mode, whatever the value of bit 1.
- R6: In Idle mode, `hf_gen_en` equals the inverse of bit 1. A write to bit 1 while in Idle takes effect on the next cycle.
- R7: A wake-up event clears bits 1 and 2 and returns the block to Active when the high-frequency clock is stable.
- R8: When the low-frequency clock is not stable, a qualified wait strobe leaves the block in Active with `stall` at 1. Idle is then entered at the first edge at which the synchronized indication is 1, and `stall` returns to 0, with no further write.
- R9: A wake-up in Idle while the high-frequency clock is not stable keeps the block in Idle with `stall` at 1. Active is entered at the first edge at which the synchronized indication is 1.
- R10: A wake-up event in the same cycle as a wait strobe, or during a pending Idle entry, keeps the block in Active and clears any pending stall.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Register and state clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read value |
| wait_strobe | input | 1 | One-cycle pulse from the core on its wait instruction |
| wake_evt | input | 1 | Hardware wake-up event |
| hf_stable_async | input | 1 | High-frequency generator stable, asynchronous |
| lf_stable_async | input | 1 | Low-frequency generator stable, asynchronous |
| mode_idle | output | 1 | 1 in Idle, 0 in Active |
| hf_gen_en | output | 1 | High-frequency generator enable |
| stall | output | 1 | A mode change is waiting on an unstable clock |

## Verification
The hardest situations to reach are the stalled transitions. In these, the request arrives while the synchronized clock indication is still low, and the release happens several cycles later on an edge fixed by the synchronizer depth.

The stimulus drops a stable input at least two cycles before the wait strobe or wake-up, so the synchronized copy is already 0. It keeps the strobe to a single cycle, then raises the input and checks that the stall persists through the synchronizer latency and clears at the exact cycle predicted.

A wake-up that arrives during a pending Idle entry is also driven. It shows that the pending request is dropped and does not complete once the clock returns.

// File: rtl/pwr_mode_ctl.sv
module pwr_mode_ctl #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata,
  input  logic       wait_strobe,
  input  logic       wake_evt,
  input  logic       hf_stable_async,
  input  logic       lf_stable_async,
  output logic       mode_idle,
  output logic       hf_gen_en,
  output logic       stall
);

  localparam int TOP = SYNC_STAGES - 1;

  logic [TOP:0] hf_sync, lf_sync;
  logic hf_ok, lf_ok;
  logic osc_off, idle_req, wait_arm;
  logic pend_idle, pend_act;
  logic go_idle, go_act;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hf_sync <= '0;
      lf_sync <= '0;
    end else begin
      hf_sync <= {hf_sync[TOP-1:0], hf_stable_async};
      lf_sync <= {lf_sync[TOP-1:0], lf_stable_async};
    end
  end

  assign hf_ok = hf_sync[TOP];
  assign lf_ok = lf_sync[TOP];

  assign go_idle = pend_idle | (wait_strobe & idle_req & wait_arm);
  assign go_act  = pend_act | wake_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      osc_off  <= 1'b0;
      idle_req <= 1'b0;
      wait_arm <= 1'b0;
    end else begin
      if (reg_wr) wait_arm <= reg_wdata[5];
      if (wake_evt) begin
        osc_off  <= 1'b0;
        idle_req <= 1'b0;
      end else if (reg_wr) begin
        osc_off  <= reg_wdata[1];
        idle_req <= reg_wdata[2];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_idle <= 1'b0;
      pend_idle <= 1'b0;
      pend_act  <= 1'b0;
    end else if (!mode_idle) begin
      pend_act <= 1'b0;
      if (wake_evt) begin
        pend_idle <= 1'b0;
      end else if (go_idle) begin
        if (lf_ok) begin
          mode_idle <= 1'b1;
          pend_idle <= 1'b0;
        end else begin
          pend_idle <= 1'b1;
        end
      end
    end else begin
      pend_idle <= 1'b0;
      if (go_act) begin
        if (hf_ok) begin
          mode_idle <= 1'b0;
          pend_act  <= 1'b0;
        end else begin
          pend_act <= 1'b1;
        end
      end
    end
  end

  assign hf_gen_en = ~mode_idle | ~osc_off;
  assign stall     = pend_idle | pend_act;
  assign reg_rdata = {lf_ok, hf_ok, wait_arm, 2'b00, idle_req, osc_off, 1'b0};

  // R4
  idle_entry_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_idle) |-> ($past(pend_idle) || ($past(wait_strobe) && $past(idle_req) && $past(wait_arm))));

  // R8
  idle_entry_lf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mode_idle) |-> $past(lf_ok));

  // R9
  active_entry_hf_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_idle) |-> $past(hf_ok));

  // R7
  wake_clears_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wake_evt |=> (!idle_req && !osc_off));

  // R10
  wake_beats_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_evt && !mode_idle) |=> (!mode_idle && !pend_idle));

  // R5
  active_hf_on_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(mode_idle) |-> hf_gen_en);

endmodule

// File: tb/pwr_mode_ctl_tb.sv
`timescale 1ns/1ps
module pwr_mode_ctl_tb_top;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;
  logic wait_strobe = 1'b0;
  logic wake_evt = 1'b0;
  logic hf_a = 1'b0;
  logic lf_a = 1'b0;
  logic mode_idle, hf_gen_en, stall;

  int total = 0;
  int bad = 0;
  bit done = 0;

  always #4 clk = ~clk;

  pwr_mode_ctl dut_i (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .wait_strobe(wait_strobe), .wake_evt(wake_evt),
    .hf_stable_async(hf_a), .lf_stable_async(lf_a),
    .mode_idle(mode_idle), .hf_gen_en(hf_gen_en), .stall(stall)
  );

  // wr, wdata, wait, wake, hf, lf | mode, en, stall, rdata
  localparam int NV = 27;
  localparam logic [23:0] VEC [NV] = '{
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'h00},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC0},
    {1'b1, 8'h26, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0},
    {1'b1, 8'hFF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 8'h66},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h66},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 8'h66},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'h66},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b1, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 8'hA6},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hA0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 8'hE0},
    {1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0},
    {1'b1, 8'h24, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE4},
    {1'b0, 8'h00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0},
    {1'b1, 8'h04, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC4},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hC4},
    {1'b1, 8'h26, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE6},
    {1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 8'hE6},
    {1'b1, 8'h24, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 8'hE4},
    {1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 8'hE0}
  };

  task automatic check(input string req, input logic [10:0] act, input logic [10:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: mode/en/stall/rdata actual=%b_%b_%b_%h expected=%b_%b_%b_%h",
               req, act[10], act[9], act[8], act[7:0], exp[10], exp[9], exp[8], exp[7:0]);
    end
  endtask

  task automatic step(input logic wr, input logic [7:0] wd, input logic wt,
                      input logic wk, input logic hf, input logic lf);
    reg_wr = wr; reg_wdata = wd; wait_strobe = wt; wake_evt = wk; hf_a = hf; lf_a = lf;
    @(negedge clk);
  endtask

  function automatic string tag(input int i);
    case (i)
      0, 1: tag = "R3";
      2, 5, 19, 21: tag = "R2";
      3, 22, 24: tag = "R4";
      4, 26: tag = "R7";
      6, 7, 13, 14: tag = "R3";
      8, 9, 10, 11, 12: tag = "R8";
      15, 16, 17, 18: tag = "R9";
      20: tag = "R10";
      25: tag = "R6";
      default: tag = "R5";
    endcase
  endfunction

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b0, 8'h00});
    rst_n = 1'b1;
    @(negedge clk);
    for (int i = 0; i < NV; i++) begin
      step(VEC[i][23], VEC[i][22:15], VEC[i][14], VEC[i][13], VEC[i][12], VEC[i][11]);
      check(tag(i), {mode_idle, hf_gen_en, stall, reg_rdata}, VEC[i][10:0]);
    end
    // R5: Active with oscillator-disable bit set keeps enable high
    step(1'b1, 8'h02, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R5", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b0, 8'hC2});
    // R10: wake-up during a pending Idle entry drops the request
    step(1'b1, 8'h26, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0);
    step(1'b0, 8'h00, 1'b1, 1'b0, 1'b1, 1'b0);
    check("R8", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b1, 8'h66});
    step(1'b0, 8'h00, 1'b0, 1'b1, 1'b1, 1'b0);
    check("R10", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b0, 8'h60});
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    step(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b1);
    check("R10", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b0, 8'hE0});
    // R1: reset mid-run clears everything
    rst_n = 1'b0;
    @(negedge clk);
    check("R1", {mode_idle, hf_gen_en, stall, reg_rdata}, {1'b0, 1'b1, 1'b0, 8'h00});
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

endmodule